// File: doc/BRIEF.md
# MDIO Pseudo-PHY Register Bridge

This engine lets a host reach a wide, paged register space that sits behind a single MDIO pseudo-PHY. The host issues one request that carries the page number, the register offset and the access length: 1, 2, 4, 6 or 8 bytes. For a write, the request also carries the data. The engine breaks the request into a series of 16-bit management frames and hands each one to a neighbouring MDIO frame engine over a valid/ready port. That neighbour performs the serial MDC/MDIO signalling and returns 16 bits for each read frame.

Each request is handled in these steps:

1. If the requested page differs from the last one used, the engine selects the page. A page cache avoids this frame when the page is unchanged.
2. For a write, it loads the data registers in a fixed descending order.
3. It writes the command register with the offset and the opcode.
4. It reads the command register back until the opcode bits clear, or until a poll budget is spent.
5. For a read, it collects the data registers and packs them into a little-endian byte vector.

A request with a length the engine cannot express is refused at once. No frame is sent for it.

Top module: `pphy_bridge`

## Requirements
- R1: Every frame the engine presents carries PHY address 0x1E on `frm_phy`.
- R2: The first access after reset, and any access whose page differs from the previous successful page selection, begins with a write frame to register 0x10 whose data is the page in bits [15:8] and 1 in bit 0. An access to the same page as the previous one sends no page frame.
- R3: For a write, the data frames precede the command frame. They are written to registers 0x18+i, with i counting down from N-1 to 0, where N is 4 for 8 bytes, 3 for 6 bytes, 2 for 4 bytes and 1 for 1 or 2 bytes. Register 0x18+i receives request bytes 2i+1 (high) and 2i (low). A 1-byte write sends only byte 0, with the upper 8 bits zero.
- R4: The command frame is a write to register 0x11 with the register offset in bits [15:8], zero in bits [7:2] and the opcode in bits [1:0]: 1 for a write, 2 for a read.
- R5: After the command frame, the engine issues read frames to register 0x11 until one returns zero in bits [1:0]. A write request then completes with `rsp_err` low.
- R6: If 100 consecutive polls all return a nonzero opcode field, the request completes with `rsp_err` high, and no data register is read.
- R7: For a read, after completion the engine reads registers 0x18+(N-1) down to 0x18. Word i supplies result byte 2i+1 (from bits [15:8]) and byte 2i (from bits [7:0]). Bytes beyond the length are zero, and `rsp_err` is low.
- R8: A 1-byte read returns only bits [7:0] of register 0x18; bits [63:8] of the result are zero.
- R9: A request with a length other than 1, 2, 4, 6 or 8 produces no frame. It also leaves the page cache unchanged. It completes with `rsp_err` high in the cycle after acceptance.
- R10: `req_ready` is high only while the engine is idle. A frame held while `frm_ready` is low keeps `frm_valid` high and its write flag, address and data unchanged.
- R11: Each accepted request yields exactly one `rsp_valid` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request taken when valid |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_page | input | 8 | Target page |
| req_reg | input | 8 | Register offset within the page |
| req_len | input | 4 | Access length in bytes |
| req_wdata | input | 64 | Write data, byte 0 in bits [7:0] |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Bad length or poll timeout |
| rsp_rdata | output | 64 | Read result, byte 0 in bits [7:0] |
| frm_valid | output | 1 | Frame offered to the MDIO frame engine |
| frm_ready | input | 1 | Frame engine accepts the frame |
| frm_write | output | 1 | 1 = write frame, 0 = read frame |
| frm_phy | output | 5 | PHY address of the frame |
| frm_addr | output | 5 | Register address of the frame |
| frm_wdata | output | 16 | Write frame data |
| frm_rvalid | input | 1 | Read frame result present |
| frm_rdata | input | 16 | Read frame result |

## Verification
The assertions check several properties on every cycle:

- a frame held under back-pressure stays unchanged;
- a command write is followed directly by a status poll;
- a bad length leads straight to an error response;
- the poll counter never advances past its budget;
- the response pulse stays one cycle long;
- a 1-byte read result never carries upper bits.

Only the bench's scenarios can show the full frame order for each length, and when the page frame is skipped or restored after reset. They also show the exact byte packing of read results against a modelled register set, and the 100-poll timeout boundary.

// File: rtl/pphy_pkg.sv
package pphy_pkg;
    localparam int PAGE_W = 8;
    localparam int REG_W  = 8;
    localparam int NREG   = 4;
    localparam int WORD_W = 16;
    localparam int DATA_W = NREG * WORD_W;
    localparam int IDX_W  = $clog2(NREG);
    localparam int LEN_W  = 4;

    localparam logic [4:0] A_PAGE  = 5'h10;
    localparam logic [4:0] A_CMD   = 5'h11;
    localparam logic [4:0] A_DATA0 = 5'h18;

    localparam logic [1:0] OP_WR = 2'd1;
    localparam logic [1:0] OP_RD = 2'd2;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PAGE, ST_WDAT, ST_CMD,
        ST_PREQ, ST_PWAIT, ST_RREQ, ST_RWAIT, ST_DONE
    } state_t;

    typedef struct packed {
        logic              wr;
        logic [PAGE_W-1:0] page;
        logic [REG_W-1:0]  regoff;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] wdata;
    } req_t;

    typedef struct packed {
        logic              wr;
        logic [4:0]        addr;
        logic [WORD_W-1:0] data;
    } frame_t;

    // number of 16-bit data registers an access length needs; 0 = illegal
    function automatic logic [IDX_W:0] regs_for_len(input logic [LEN_W-1:0] len);
        logic [IDX_W:0] n;
        case (len)
            4'd1, 4'd2: n = (IDX_W+1)'(1);
            4'd4:       n = (IDX_W+1)'(2);
            4'd6:       n = (IDX_W+1)'(3);
            4'd8:       n = (IDX_W+1)'(4);
            default:    n = '0;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/pphy_page_cache.sv
module pphy_page_cache #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd,
    input  logic [PW-1:0] upd_page,
    input  logic [PW-1:0] lookup,
    output logic          hit
);
    logic          vld_q;
    logic [PW-1:0] page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            page_q <= '0;
        end else if (upd) begin
            vld_q  <= 1'b1;
            page_q <= upd_page;
        end
    end

    assign hit = vld_q && (page_q == lookup);

    // R2: a completed page selection makes the next lookup of that page hit
    a_r2_cache_fill: assert property (@(posedge clk) disable iff (rst)
        upd |=> (vld_q && page_q == $past(upd_page)));
endmodule

// File: rtl/pphy_poll_ctr.sv
module pphy_poll_ctr #(
    parameter int MAX = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(MAX + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else if (inc)   cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == CW'(MAX - 1));

    // R6: the sequencer never asks for a poll beyond the budget
    a_r6_poll_budget: assert property (@(posedge clk) disable iff (rst)
        inc |-> (cnt_q < CW'(MAX)));
endmodule

// File: rtl/pphy_rd_asm.sv
module pphy_rd_asm #(
    parameter int NR = 4,
    parameter int WW = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   load,
    input  logic [$clog2(NR)-1:0]  idx,
    input  logic [WW-1:0]          word,
    input  logic                   one_byte,
    output logic [NR*WW-1:0]       data
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            data <= '0;
        end else if (load) begin
            if (one_byte) data[idx*WW +: WW] <= {{(WW-8){1'b0}}, word[7:0]};
            else          data[idx*WW +: WW] <= word;
        end
    end

    // R8: a single-byte result never carries bits above byte 0
    a_r8_low_byte_only: assert property (@(posedge clk) disable iff (rst)
        (one_byte && !clr && !load) |-> (data[NR*WW-1:8] == '0));
endmodule

// File: rtl/pphy_bridge.sv
module pphy_bridge
    import pphy_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR = 5'h1E,
    parameter int         MAX_POLL = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              frm_valid,
    input  logic              frm_ready,
    output logic              frm_write,
    output logic [4:0]        frm_phy,
    output logic [4:0]        frm_addr,
    output logic [WORD_W-1:0] frm_wdata,
    input  logic              frm_rvalid,
    input  logic [WORD_W-1:0] frm_rdata
);
    state_t           st;
    req_t             rq;
    logic [IDX_W-1:0] idx;
    logic             err_q;
    frame_t           fr;

    logic             acc, fire, pg_hit, poll_last, busy_rsp;
    logic [IDX_W:0]   nreg_in, nreg_q;

    assign req_ready = (st == ST_IDLE);
    assign acc       = req_valid && req_ready;
    assign fire      = frm_valid && frm_ready;
    assign nreg_in   = regs_for_len(req_len);
    assign nreg_q    = regs_for_len(rq.len);
    assign busy_rsp  = (frm_rdata[1:0] != 2'b00);

    pphy_page_cache #(.PW(PAGE_W)) cache_i (
        .clk      (clk),
        .rst      (rst),
        .upd      (st == ST_PAGE && fire),
        .upd_page (rq.page),
        .lookup   (req_page),
        .hit      (pg_hit)
    );

    pphy_poll_ctr #(.MAX(MAX_POLL)) poll_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (st == ST_CMD && fire),
        .inc  (st == ST_PWAIT && frm_rvalid && busy_rsp),
        .last (poll_last)
    );

    pphy_rd_asm #(.NR(NREG), .WW(WORD_W)) asm_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (acc),
        .load     (st == ST_RWAIT && frm_rvalid),
        .idx      (idx),
        .word     (frm_rdata),
        .one_byte (rq.len == LEN_W'(1)),
        .data     (rsp_rdata)
    );

    // sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            rq    <= '0;
            idx   <= '0;
            err_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (acc) begin
                    rq    <= '{wr: req_write, page: req_page, regoff: req_reg,
                               len: req_len, wdata: req_wdata};
                    idx   <= IDX_W'(nreg_in - 1'b1);
                    err_q <= 1'b0;
                    if (nreg_in == '0) begin
                        err_q <= 1'b1;
                        st    <= ST_DONE;
                    end else if (!pg_hit) begin
                        st <= ST_PAGE;
                    end else begin
                        st <= req_write ? ST_WDAT : ST_CMD;
                    end
                end
                ST_PAGE: if (fire) st <= rq.wr ? ST_WDAT : ST_CMD;
                ST_WDAT: if (fire) begin
                    if (idx == '0) st <= ST_CMD;
                    else           idx <= idx - 1'b1;
                end
                ST_CMD:  if (fire) st <= ST_PREQ;
                ST_PREQ: if (fire) st <= ST_PWAIT;
                ST_PWAIT: if (frm_rvalid) begin
                    if (!busy_rsp) begin
                        if (rq.wr) begin
                            st <= ST_DONE;
                        end else begin
                            idx <= IDX_W'(nreg_q - 1'b1);
                            st  <= ST_RREQ;
                        end
                    end else if (poll_last) begin
                        err_q <= 1'b1;
                        st    <= ST_DONE;
                    end else begin
                        st <= ST_PREQ;
                    end
                end
                ST_RREQ: if (fire) st <= ST_RWAIT;
                ST_RWAIT: if (frm_rvalid) begin
                    if (idx == '0) st <= ST_DONE;
                    else begin
                        idx <= idx - 1'b1;
                        st  <= ST_RREQ;
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // frame formation
    always_comb begin
        fr = '0;
        case (st)
            ST_PAGE: begin
                fr.wr   = 1'b1;
                fr.addr = A_PAGE;
                fr.data = {rq.page, 7'b0, 1'b1};
            end
            ST_WDAT: begin
                fr.wr   = 1'b1;
                fr.addr = A_DATA0 + 5'(idx);
                if (rq.len == LEN_W'(1)) fr.data = {8'h00, rq.wdata[7:0]};
                else                     fr.data = rq.wdata[idx*WORD_W +: WORD_W];
            end
            ST_CMD: begin
                fr.wr   = 1'b1;
                fr.addr = A_CMD;
                fr.data = {rq.regoff, 6'b0, (rq.wr ? OP_WR : OP_RD)};
            end
            ST_PREQ: begin
                fr.wr   = 1'b0;
                fr.addr = A_CMD;
            end
            ST_RREQ: begin
                fr.wr   = 1'b0;
                fr.addr = A_DATA0 + 5'(idx);
            end
            default: fr = '0;
        endcase
    end

    assign frm_valid = (st == ST_PAGE) || (st == ST_WDAT) || (st == ST_CMD) ||
                       (st == ST_PREQ) || (st == ST_RREQ);
    assign frm_write = fr.wr;
    assign frm_addr  = fr.addr;
    assign frm_wdata = fr.data;
    assign frm_phy   = PHY_ADDR;

    assign rsp_valid = (st == ST_DONE);
    assign rsp_err   = err_q;

    // R10: a stalled frame is held unchanged
    a_r10_frame_hold: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !frm_ready) |=>
            (frm_valid && $stable(frm_write) && $stable(frm_addr) && $stable(frm_wdata)));

    // R10: no frame is offered while a new request can be taken
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !frm_valid);

    // R5: the command write is followed directly by a status poll
    a_r5_poll_follows: assert property (@(posedge clk) disable iff (rst)
        (fire && frm_write && frm_addr == A_CMD) |=>
            (frm_valid && !frm_write && frm_addr == A_CMD));

    // R9: an illegal length ends in an error response with no frame
    a_r9_bad_len: assert property (@(posedge clk) disable iff (rst)
        (acc && nreg_in == '0) |=> (rsp_valid && rsp_err && !frm_valid));

    // R11: the response is a single-cycle pulse
    a_r11_one_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

// File: tb/pphy_bridge_tb_top.sv
module pphy_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_page = '0, req_reg = '0;
    logic [3:0]  req_len = '0;
    logic [63:0] req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic        frm_valid, frm_write;
    logic        frm_ready = 1'b1;
    logic [4:0]  frm_phy, frm_addr;
    logic [15:0] frm_wdata;
    logic        frm_rvalid = 1'b0;
    logic [15:0] frm_rdata = '0;

    always #2 clk = ~clk;

    pphy_bridge dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_page(req_page), .req_reg(req_reg), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_write(frm_write),
        .frm_phy(frm_phy), .frm_addr(frm_addr), .frm_wdata(frm_wdata),
        .frm_rvalid(frm_rvalid), .frm_rdata(frm_rdata)
    );

    int nchk = 0, nerr = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- frame-engine model and monitors ----------------
    logic [15:0] dregs [4];
    int          busy_left = 0;
    bit          stall_mode = 1'b0, tog = 1'b0;
    bit          rd_pending = 1'b0, prev_stall = 1'b0, rsp_prev = 1'b0;
    logic [15:0] rd_val = '0, p_d = '0;
    logic [4:0]  p_a = '0;
    logic        p_w = 1'b0;
    int          phy_bad = 0, hold_bad = 0, dbl_rsp = 0, rsp_seen = 0;
    logic        rsp_err_c = 1'b0;
    logic [63:0] rsp_data_c = '0;
    logic        lg_w [256];
    logic [4:0]  lg_a [256];
    logic [15:0] lg_d [256];
    int          lg_n = 0;

    initial begin
        forever begin
            @(negedge clk);
            frm_rvalid = 1'b0;
            if (rd_pending) begin
                frm_rvalid = 1'b1;
                frm_rdata  = rd_val;
                rd_pending = 1'b0;
            end
            if (prev_stall && !(frm_valid && frm_write == p_w && frm_addr == p_a && frm_wdata == p_d))
                hold_bad++;
            tog       = ~tog;
            frm_ready = stall_mode ? tog : 1'b1;
            prev_stall = frm_valid && !frm_ready;
            p_w = frm_write; p_a = frm_addr; p_d = frm_wdata;
            if (frm_valid && frm_ready && !rst) begin
                if (frm_phy != 5'h1E) phy_bad++;
                if (lg_n < 256) begin
                    lg_w[lg_n] = frm_write; lg_a[lg_n] = frm_addr; lg_d[lg_n] = frm_wdata;
                    lg_n++;
                end
                if (!frm_write) begin
                    rd_pending = 1'b1;
                    if (frm_addr == 5'h11) begin
                        if (busy_left > 0) begin rd_val = 16'h0002; busy_left--; end
                        else rd_val = 16'h0000;
                    end else if (frm_addr >= 5'h18 && frm_addr <= 5'h1B) begin
                        rd_val = dregs[frm_addr - 5'h18];
                    end else rd_val = 16'h0000;
                end
            end
            if (rsp_valid && !rst) begin
                if (rsp_prev) dbl_rsp++;
                rsp_seen++;
                rsp_err_c  = rsp_err;
                rsp_data_c = rsp_rdata;
            end
            rsp_prev = rsp_valid;
        end
    end

    // ---------------- expected-value model from the requirements ----------------
    bit          ex_cache_v = 1'b0;
    logic [7:0]  ex_cache_pg = '0;
    logic        ex_w [256];
    logic [4:0]  ex_a [256];
    logic [15:0] ex_d [256];
    bit          ex_dc [256];
    int          ex_n = 0;

    function automatic int nregs_of(input logic [3:0] len);
        case (len)
            4'd1, 4'd2: return 1;
            4'd4:       return 2;
            4'd6:       return 3;
            4'd8:       return 4;
            default:    return 0;
        endcase
    endfunction

    task automatic ex_add(input logic w, input logic [4:0] a, input logic [15:0] d, input bit dc);
        ex_w[ex_n] = w; ex_a[ex_n] = a; ex_d[ex_n] = d; ex_dc[ex_n] = dc; ex_n++;
    endtask

    function automatic string tag_of(input logic w, input logic [4:0] a);
        if (a == 5'h10) return "R2 page frame";
        if (a == 5'h11) return w ? "R4 command frame" : "R5 poll frame";
        return w ? "R3 data write frame" : "R7 data read frame";
    endfunction

    int case_no = 0;

    task automatic run_case(input logic wr, input logic [7:0] pg, input logic [7:0] ro,
                            input logic [3:0] ln, input logic [63:0] wd, input int busy);
        int          n, npoll;
        bit          tmo;
        logic [63:0] exp_rd;
        n   = nregs_of(ln);
        tmo = (n != 0) && (busy >= 100);
        case_no++;
        for (int i = 0; i < 4; i++) dregs[i] = 16'((i + 1) * 'h1357 + case_no * 'h0F0F);
        busy_left = busy;
        ex_n = 0;
        exp_rd = '0;
        if (n != 0) begin
            if (!ex_cache_v || ex_cache_pg != pg) begin
                ex_add(1'b1, 5'h10, {pg, 8'h01}, 1'b1);
                ex_cache_v = 1'b1; ex_cache_pg = pg;
            end
            if (wr) begin
                for (int i = n - 1; i >= 0; i--)
                    ex_add(1'b1, 5'(5'h18 + i), (ln == 4'd1) ? {8'h00, wd[7:0]} : wd[i*16 +: 16], 1'b1);
            end
            ex_add(1'b1, 5'h11, {ro, wr ? 8'h01 : 8'h02}, 1'b1);
            npoll = tmo ? 100 : busy + 1;
            for (int i = 0; i < npoll; i++) ex_add(1'b0, 5'h11, 16'h0, 1'b0);
            if (!wr && !tmo) begin
                for (int i = n - 1; i >= 0; i--) ex_add(1'b0, 5'(5'h18 + i), 16'h0, 1'b0);
                for (int i = 0; i < n; i++) exp_rd[i*16 +: 16] = dregs[i];
                if (ln == 4'd1) exp_rd = {56'h0, dregs[0][7:0]};
            end
        end
        lg_n = 0; rsp_seen = 0; phy_bad = 0; dbl_rsp = 0;

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_page = pg; req_reg = ro; req_len = ln; req_wdata = wd;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (n == 0) begin
            @(negedge clk); #1;
            check(rsp_valid && rsp_err, "R9 error one cycle after accept", longint'({rsp_valid, rsp_err}), 64'h3);
        end else begin
            check(!req_ready, "R10 ready low while busy", longint'(req_ready), 64'h0);
        end
        for (int k = 0; k < 3000; k++) begin
            if (rsp_seen > 0) break;
            @(posedge clk);
        end
        @(negedge clk); @(negedge clk); #1;

        check(rsp_seen == 1 && dbl_rsp == 0, "R11 single response pulse", longint'(rsp_seen), 64'h1);
        check(lg_n == ex_n, (n == 0) ? "R9 no frames for bad length" : "R3 frame count",
              longint'(lg_n), longint'(ex_n));
        if (lg_n == ex_n) begin
            for (int i = 0; i < ex_n; i++)
                check(lg_w[i] == ex_w[i] && lg_a[i] == ex_a[i] && (!ex_dc[i] || lg_d[i] == ex_d[i]),
                      tag_of(ex_w[i], ex_a[i]),
                      longint'({lg_w[i], lg_a[i], lg_d[i]}), longint'({ex_w[i], ex_a[i], ex_d[i]}));
        end
        if (n != 0) check(phy_bad == 0, "R1 PHY address 0x1E", longint'(phy_bad), 64'h0);
        if (n == 0) check(rsp_err_c, "R9 error flag", longint'(rsp_err_c), 64'h1);
        else if (tmo) check(rsp_err_c, "R6 timeout error", longint'(rsp_err_c), 64'h1);
        else check(!rsp_err_c, wr ? "R5 write completes clean" : "R7 read completes clean",
                   longint'(rsp_err_c), 64'h0);
        if (!wr && n != 0 && !tmo)
            check(rsp_data_c == exp_rd, (ln == 4'd1) ? "R8 one-byte read data" : "R7 read data packing",
                  longint'(rsp_data_c), longint'(exp_rd));
    endtask

    typedef struct packed {
        logic        wr;
        logic [7:0]  pg;
        logic [7:0]  ro;
        logic [3:0]  ln;
        logic [63:0] wd;
        logic [7:0]  busy;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b1, 8'h02, 8'h30, 4'd2, 64'h0000_0000_0000_1234, 8'd0},
        '{1'b1, 8'h02, 8'h06, 4'd4, 64'h0000_0000_A1B2_C3D4, 8'd3},
        '{1'b0, 8'h02, 8'h30, 4'd2, 64'h0,                    8'd1},
        '{1'b1, 8'h34, 8'h08, 4'd8, 64'h1122_3344_5566_7788, 8'd2},
        '{1'b0, 8'h34, 8'h10, 4'd6, 64'h0,                    8'd0},
        '{1'b0, 8'h05, 8'h10, 4'd8, 64'h0,                    8'd5},
        '{1'b1, 8'h05, 8'h0B, 4'd1, 64'hFFEE_DDCC_BBAA_9988, 8'd0},
        '{1'b0, 8'h00, 8'h0E, 4'd1, 64'h0,                    8'd2},
        '{1'b0, 8'h00, 8'h20, 4'd4, 64'h0,                    8'd0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        check(req_ready && !frm_valid && !rsp_valid, "R10 reset state idle",
              longint'({req_ready, frm_valid, rsp_valid}), 64'h4);

        // vector table: writes and reads of every length, page hits and misses
        for (int v = 0; v < 9; v++)
            run_case(VECS[v].wr, VECS[v].pg, VECS[v].ro, VECS[v].ln, VECS[v].wd, int'(VECS[v].busy));

        // R9: illegal lengths
        run_case(1'b1, 8'h07, 8'h01, 4'd3, 64'h55, 0);
        run_case(1'b0, 8'h07, 8'h01, 4'd0, 64'h0, 0);
        // R9: cache unaffected, same page as before sends no page frame
        run_case(1'b0, 8'h00, 8'h02, 4'd2, 64'h0, 0);

        // R6: timeout boundary, 99 busy polls still succeed, 100 fail
        run_case(1'b0, 8'h00, 8'h04, 4'd2, 64'h0, 99);
        run_case(1'b0, 8'h00, 8'h04, 4'd2, 64'h0, 200);

        // R10: back-pressure on the frame port
        stall_mode = 1'b1;
        hold_bad = 0;
        run_case(1'b1, 8'h09, 8'h40, 4'd8, 64'h0102_0304_0506_0708, 1);
        run_case(1'b0, 8'h09, 8'h40, 4'd6, 64'h0, 2);
        check(hold_bad == 0, "R10 stalled frame held", longint'(hold_bad), 64'h0);
        stall_mode = 1'b0;

        // R2: reset empties the page cache, same page needs a new page frame
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        ex_cache_v = 1'b0;
        run_case(1'b1, 8'h09, 8'h44, 4'd2, 64'hBEEF, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule